// File: doc/BRIEF.md
# 2-D Wavelet Tile Transformer

This block runs a separable two-dimensional integer wavelet transform (the reversible 5/3 lifting pair) over a square tile of pixels. The tile lives in an on-chip single-port memory. The pixels arrive row by row on a valid/ready stream. Each row is gathered into a line buffer, lifted horizontally and written to memory, so the memory only ever holds horizontal results. After the last row is stored, the controller walks the columns. It reads each column into the line buffer, lifts it vertically and writes it back in place.

A run is started with a level count. Every level after the first repeats the same row pass and column pass on the top-left quadrant of the previous level, which holds the low-low band. The row data for these later levels comes from memory and not from the stream. When the run is finished, a one-cycle done pulse is raised. The coefficients stay in memory, and the host reads them through a simple address/data port.

Top module: `dwt2d_tile`

## Requirements
- R1: `pix_ready` is low out of reset and while idle. During level 0 it drops for exactly TILE_N cycles after each of the first TILE_N-1 rows, while that row is written to memory, and is high otherwise until the last pixel is taken.
- R2: A pixel is taken on a rising edge where `pix_valid` and `pix_ready` are both high. Pixels fill the tile in row-major order, starting at row 0, column 0. `pix_valid` while `pix_ready` is low has no effect on the result.
- R3: The horizontal pass over a line x[0..L-1] produces d[k] = x[2k+1] - floor((x[2k]+x[2k+2])/2) and s[k] = x[2k] + floor((d[k-1]+d[k]+2)/4). Samples are mirrored at both ends, so x[L] = x[L-2] and d[-1] = d[0]. s[k] is stored at index k and d[k] at index L/2+k of that line.
- R4: The vertical pass starts only after all rows of the active region have been stored. It applies the same lifting to every column of the active region and writes the results back in place, with low band at the upper rows and high band at the lower rows.
- R5: Level l (counted from 0) transforms only the top-left (TILE_N>>l)-square, and words outside it keep their values. `levels` is sampled at start and must lie in 1..log2(TILE_N)-1.
- R6: `done` is high for exactly one cycle when the last level is finished. After that, `rd_data` shows, one cycle after `rd_addr` is presented, the word at address row*TILE_N+col as a signed two's complement value of COEF_W bits.
- R7: The memory is never asked for a read and a write in the same cycle.
- R8: A `start` pulse while a run is in progress is ignored, and the level count of the running transform is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| levels | input | LVL_W | Number of decomposition levels |
| pix_valid | input | 1 | Pixel on `pix_data` is valid |
| pix_data | input | PIX_W | Unsigned pixel |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | ADDR_W | Host read address (row*TILE_N+col) |
| rd_data | output | COEF_W | Coefficient read, one cycle latency |

## Verification
The assertions assume that `levels` is in range whenever an idle block sees `start`. The bench only requests one, two or three levels on a 16-wide tile, and its one out-of-run start pulse also carries a legal count. Coefficient growth is assumed to fit COEF_W. The stimulus uses 8-bit pixels, so every value stays far inside 16 bits, and the bench model can use plain integers without wrap-around. Host reads are assumed to happen only while the block is idle, and the bench reads only after the done pulse.

// File: rtl/dwt2d_pkg.sv
package dwt2d_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW_IN,
    S_ROW_WRITE,
    S_ROW_READ,
    S_COL_READ,
    S_COL_WRITE,
    S_NEXT_LEVEL,
    S_DONE
  } dwt_state_e;

  // Whole-sample symmetric extension of an index into [0, len-1].
  function automatic int mirror_idx(input int i, input int len);
    if (i < 0) return -i;
    if (i >= len) return 2 * len - 2 - i;
    return i;
  endfunction

  // Predict: odd sample minus the floored mean of its even neighbours.
  function automatic int lift_predict(input int left, input int mid, input int right);
    return mid - ((left + right) >>> 1);
  endfunction

  // Update: even sample plus a rounded quarter of the two nearby details.
  function automatic int lift_update(input int even, input int det_l, input int det_r);
    return even + ((det_l + det_r + 2) >>> 2);
  endfunction

endpackage

// File: rtl/dwt_tile_ram.sv
module dwt_tile_ram #(
  parameter int DEPTH = 256,
  parameter int CW    = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] cells [DEPTH];

  // Single port: one access per cycle, write has priority over read.
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    else    rdata       <= cells[addr];
  end
endmodule

// File: rtl/dwt_line_buf.sv
module dwt_line_buf #(
  parameter int N  = 16,
  parameter int CW = 16,
  parameter int IW = 4,
  parameter int LW = 5
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [CW-1:0]   wr_data,
  input  logic [IW-1:0]   center,
  input  logic [LW-1:0]   len,
  output logic [5*CW-1:0] taps
);
  localparam int TAPS = 5;

  logic [CW-1:0] cells [N];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  function automatic logic [IW-1:0] tap_index(input logic [IW-1:0] c,
                                              input logic [LW-1:0] l,
                                              input int off);
    return IW'(dwt2d_pkg::mirror_idx(int'(c) + off, int'(l)));
  endfunction

  // Five-sample window around the centre; slot t holds offset t-2.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign taps[t*CW +: CW] = cells[tap_index(center, len, t - 2)];
  end
endmodule

// File: rtl/dwt_lift_core.sv
module dwt_lift_core #(
  parameter int CW = 16
) (
  input  logic [5*CW-1:0] taps,
  input  logic            hi_sel,
  output logic [CW-1:0]   coef
);
  int x [5];
  int det_l, det_r, res;

  always_comb begin
    for (int t = 0; t < 5; t++) x[t] = int'($signed(taps[t*CW +: CW]));
    det_l = dwt2d_pkg::lift_predict(x[0], x[1], x[2]);
    det_r = dwt2d_pkg::lift_predict(x[2], x[3], x[4]);
    if (hi_sel) res = dwt2d_pkg::lift_predict(x[1], x[2], x[3]);
    else        res = dwt2d_pkg::lift_update(x[2], det_l, det_r);
    coef = CW'(res);
  end
endmodule

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
  import dwt2d_pkg::*;
#(
  parameter int N    = 16,
  parameter int IW   = 4,
  parameter int LW   = 5,
  parameter int LVLW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LVLW-1:0] levels,
  input  logic            pix_valid,
  output logic            pix_ready,
  output logic            buf_wr_en,
  output logic [IW-1:0]   buf_wr_idx,
  output logic            buf_src_ram,
  output logic [IW-1:0]   win_center,
  output logic            win_hi,
  output logic [LW-1:0]   win_len,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [2*IW-1:0] mem_addr,
  output logic            done
);
  localparam int MAX_LVL = IW - 1;

  dwt_state_e      state_q, state_d;
  logic [LVLW-1:0] lvl_cnt_q, lvl_tgt_q;
  logic [LW-1:0]   len_q, pos_q;
  logic [IW-1:0]   line_q, cap_idx_q;
  logic            cap_vld_q;

  // Named events used by the next-state logic and the assertions.
  logic          pix_take, line_last, pos_last, rd_drained, lvl_last;
  logic [LW-1:0] half;
  logic [IW-1:0] pos_idx;

  assign pix_take   = pix_valid && pix_ready;
  assign line_last  = ({1'b0, line_q} == len_q - 1'b1);
  assign pos_last   = (pos_q == len_q - 1'b1);
  assign rd_drained = (pos_q == len_q);
  assign lvl_last   = ((lvl_cnt_q + 1'b1) == lvl_tgt_q);
  assign half       = len_q >> 1;
  assign pos_idx    = pos_q[IW-1:0];

  // Output position j: low band uses centre 2j, high band centre 2(j-H)+1.
  assign win_hi     = (pos_q >= half);
  assign win_center = win_hi ? IW'({pos_q - half, 1'b1}) : IW'({pos_q, 1'b0});
  assign win_len    = len_q;

  assign buf_wr_en   = (state_q == S_ROW_IN && pix_take) || cap_vld_q;
  assign buf_wr_idx  = (state_q == S_ROW_IN) ? pos_idx : cap_idx_q;
  assign buf_src_ram = cap_vld_q;
  assign done        = (state_q == S_DONE);

  always_comb begin
    state_d   = state_q;
    pix_ready = 1'b0;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_addr  = '0;
    case (state_q)
      S_IDLE: if (start) state_d = S_ROW_IN;
      S_ROW_IN: begin
        pix_ready = 1'b1;
        if (pix_take && pos_q == LW'(N - 1)) state_d = S_ROW_WRITE;
      end
      S_ROW_WRITE: begin
        mem_wr   = 1'b1;
        mem_addr = {line_q, pos_idx};
        if (pos_last) begin
          if (line_last)              state_d = S_COL_READ;
          else if (lvl_cnt_q == '0)   state_d = S_ROW_IN;
          else                        state_d = S_ROW_READ;
        end
      end
      S_ROW_READ: begin
        if (!rd_drained) begin
          mem_rd   = 1'b1;
          mem_addr = {line_q, pos_idx};
        end else begin
          state_d = S_ROW_WRITE;
        end
      end
      S_COL_READ: begin
        if (!rd_drained) begin
          mem_rd   = 1'b1;
          mem_addr = {pos_idx, line_q};
        end else begin
          state_d = S_COL_WRITE;
        end
      end
      S_COL_WRITE: begin
        mem_wr   = 1'b1;
        mem_addr = {pos_idx, line_q};
        if (pos_last) state_d = line_last ? S_NEXT_LEVEL : S_COL_READ;
      end
      S_NEXT_LEVEL: state_d = lvl_last ? S_DONE : S_ROW_READ;
      S_DONE:       state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      lvl_cnt_q <= '0;
      lvl_tgt_q <= '0;
      len_q     <= LW'(N);
      pos_q     <= '0;
      line_q    <= '0;
      cap_vld_q <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_d;
      cap_vld_q <= mem_rd;
      cap_idx_q <= pos_idx;
      case (state_q)
        S_IDLE: if (start) begin
          lvl_tgt_q <= levels;
          lvl_cnt_q <= '0;
          len_q     <= LW'(N);
          pos_q     <= '0;
          line_q    <= '0;
        end
        S_ROW_IN: if (pix_take) pos_q <= (pos_q == LW'(N - 1)) ? '0 : pos_q + 1'b1;
        S_ROW_WRITE, S_COL_WRITE: begin
          if (pos_last) begin
            pos_q  <= '0;
            line_q <= line_last ? '0 : line_q + 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        S_ROW_READ, S_COL_READ: pos_q <= rd_drained ? '0 : pos_q + 1'b1;
        S_NEXT_LEVEL: if (!lvl_last) begin
          lvl_cnt_q <= lvl_cnt_q + 1'b1;
          len_q     <= len_q >> 1;
        end
        default: ;
      endcase
    end
  end

  // R7: one memory operation per cycle.
  a_r7_single_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6: completion pulse lasts one cycle.
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: column pass is entered from the row pass only after its last row.
  a_r4_cols_after_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COL_READ && $past(state_q) == S_ROW_WRITE)
      |-> ({1'b0, $past(line_q)} == $past(len_q) - 1'b1));

  // R5: each new level works on half the previous side.
  a_r5_region_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ROW_READ && $past(state_q) == S_NEXT_LEVEL)
      |-> (len_q == ($past(len_q) >> 1)));

  // R5: input assumption on the level count at start.
  a_r5_levels_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == S_IDLE)
      |-> (levels != '0 && levels <= LVLW'(MAX_LVL)));

  // R8: a start during a run leaves the running level count alone.
  a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != S_IDLE) |=> (lvl_tgt_q == $past(lvl_tgt_q)));
endmodule

// File: rtl/dwt2d_tile.sv
module dwt2d_tile #(
  parameter int TILE_N = 16,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  localparam int IDX_W  = $clog2(TILE_N),
  localparam int LEN_W  = IDX_W + 1,
  localparam int ADDR_W = 2 * IDX_W,
  localparam int LVL_W  = $clog2(IDX_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LVL_W-1:0]  levels,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_ready,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  localparam int DEPTH = TILE_N * TILE_N;

  logic              buf_wr_en, buf_src_ram, win_hi, mem_wr, mem_rd;
  logic [IDX_W-1:0]  buf_wr_idx, win_center;
  logic [LEN_W-1:0]  win_len;
  logic [ADDR_W-1:0] mem_addr, ram_addr;
  logic [COEF_W-1:0] buf_wdata, ram_rdata, coef;
  logic [5*COEF_W-1:0] taps;

  dwt_ctrl #(.N(TILE_N), .IW(IDX_W), .LW(LEN_W), .LVLW(LVL_W)) ctrl_i (
    .clk, .rst_n, .start, .levels, .pix_valid, .pix_ready,
    .buf_wr_en, .buf_wr_idx, .buf_src_ram, .win_center, .win_hi, .win_len,
    .mem_wr, .mem_rd, .mem_addr, .done
  );

  // Pixels enter unsigned; later passes reload stored coefficients.
  assign buf_wdata = buf_src_ram ? ram_rdata
                                 : {{(COEF_W - PIX_W){1'b0}}, pix_data};

  dwt_line_buf #(.N(TILE_N), .CW(COEF_W), .IW(IDX_W), .LW(LEN_W)) line_i (
    .clk, .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wdata),
    .center(win_center), .len(win_len), .taps
  );

  dwt_lift_core #(.CW(COEF_W)) lift_i (
    .taps, .hi_sel(win_hi), .coef
  );

  // Host address reaches the memory whenever the controller is not using it.
  assign ram_addr = (mem_rd || mem_wr) ? mem_addr : rd_addr;

  dwt_tile_ram #(.DEPTH(DEPTH), .CW(COEF_W), .AW(ADDR_W)) ram_i (
    .clk, .we(mem_wr), .addr(ram_addr), .wdata(coef), .rdata(ram_rdata)
  );

  assign rd_data = ram_rdata;
endmodule

// File: tb/dwt2d_tile_tb_top.sv
`timescale 1ns/1ps
module dwt2d_tile_tb_top;
  localparam int N = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] levels = 3'd1;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic       pix_ready, done;
  logic [7:0] rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  int img [N][N];
  int refm [N][N];
  int ln [N];

  always #4 clk = ~clk;

  dwt2d_tile dut_i (
    .clk, .rst_n, .start, .levels, .pix_valid, .pix_data,
    .pix_ready, .done, .rd_addr, .rd_data
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference lifting: all details first, then all smooth values.
  function automatic void lift_line(input int len);
    int d [N];
    int s [N];
    int h = len / 2;
    for (int k = 0; k < h; k++) begin
      int nxt = (2*k + 2 < len) ? ln[2*k + 2] : ln[2*k];
      d[k] = ln[2*k + 1] - ((ln[2*k] + nxt) >>> 1);
    end
    for (int k = 0; k < h; k++) begin
      int prv = (k == 0) ? d[0] : d[k - 1];
      s[k] = ln[2*k] + ((prv + d[k] + 2) >>> 2);
    end
    for (int k = 0; k < h; k++) begin
      ln[k] = s[k];
      ln[h + k] = d[k];
    end
  endfunction

  function automatic void build_ref(input int lv);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) refm[r][c] = img[r][c];
    for (int l = 0; l < lv; l++) begin
      int len = N >> l;
      for (int r = 0; r < len; r++) begin
        for (int c = 0; c < len; c++) ln[c] = refm[r][c];
        lift_line(len);
        for (int c = 0; c < len; c++) refm[r][c] = ln[c];
      end
      for (int c = 0; c < len; c++) begin
        for (int r = 0; r < len; r++) ln[r] = refm[r][c];
        lift_line(len);
        for (int r = 0; r < len; r++) refm[r][c] = ln[r];
      end
    end
  endfunction

  // R6: read the tile through the host port and compare every word.
  task automatic read_check(input string tag);
    @(negedge clk);
    rd_addr = 8'd0;
    for (int a = 0; a < N*N; a++) begin
      @(negedge clk);
      chk(int'($signed(rd_data)) == refm[a / N][a % N], tag,
          int'($signed(rd_data)), refm[a / N][a % N]);
      rd_addr = 8'(a + 1);
    end
  endtask

  // One run: stream the tile, wait for done, compare against the model.
  task automatic run_tile(input int lv, input bit gaps, input bit junk,
                          input bit restart, input string tag);
    int k = 0;
    int lows = 0;
    int it = 0;
    int w = 0;
    @(negedge clk);
    start = 1'b1;
    levels = 3'(lv);
    while (k < N*N) begin
      @(negedge clk);
      start = restart && (it == 37);               // R8: busy start
      levels = (restart && it == 37) ? 3'((lv % 3) + 1) : 3'(lv);
      it++;
      if (!pix_ready) begin
        lows++;
        pix_valid = junk;                          // R2: ignored offer
        pix_data = 8'hA5;
      end else if (gaps && (it % 4 == 1)) begin
        pix_valid = 1'b0;
      end else begin
        pix_valid = 1'b1;
        pix_data = 8'(img[k / N][k % N]);
        k++;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    start = 1'b0;
    levels = 3'(lv);
    chk(lows == N*(N-1), "R1 ready low cycles", lows, N*(N-1));
    while (!done && w < 50000) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R6 done seen", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
    chk(pix_ready == 1'b0, "R1 ready idle", int'(pix_ready), 0);
    build_ref(lv);
    read_check(tag);
  endtask

  task automatic t_reset;
    chk(pix_ready == 1'b0, "R1 reset ready", int'(pix_ready), 0);
    chk(done == 1'b0, "R6 reset done", int'(done), 0);
  endtask

  task automatic t_flat;      // R3 R4: flat tile, details vanish
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) img[r][c] = 100;
    run_tile(1, 1'b0, 1'b0, 1'b0, "R3 R4 flat");
  endtask

  task automatic t_ramp;      // R2 R5: ramp with bubbles, two levels
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) img[r][c] = 7*r + 3*c;
    run_tile(2, 1'b1, 1'b0, 1'b0, "R2 R5 ramp");
  endtask

  task automatic t_noise;     // R3 R4 R5: noise at every legal depth
    bit [31:0] seed = 32'h1234_5678;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        img[r][c] = int'(seed[23:16]);
      end
    for (int lv = 1; lv <= 3; lv++) run_tile(lv, 1'b0, 1'b0, 1'b0, "R5 noise");
  endtask

  task automatic t_checker;   // R2 R8: junk while not ready, busy start
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) img[r][c] = ((r + c) % 2 == 0) ? 255 : 0;
    run_tile(3, 1'b1, 1'b1, 1'b1, "R2 R8 checker");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_ramp();
    t_noise();
    t_checker();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule